// File: doc/BRIEF.md
# Raster / Macroblock Frame Store Address Generator

This block produces word addresses for an external frame memory shared by two sides. The video side moves samples in raster line order. The coded side moves samples in macroblock order. Each buffer holds one frame, laid out as three planes one after another: the luma plane first, then the Cb plane, then the Cr plane, each stored row by row. There are two such buffers. One side fills a buffer while the other side drains the other buffer. The buffers trade places only when both sides have finished their frame.

The `dir` pin picks which side writes.
- With `dir` = 0, the video side writes and the macroblock side reads.
- With `dir` = 1, the macroblock side writes and the video side reads. The video side reads each stored frame twice, once for each field of an interlaced output.

Successive frames written into the same buffer start at alternating offsets, either 0 or `FIELD_OFS`. This lets new data land beside the last macroblocks that are still being consumed, instead of on top of them. `dir` may change only while reset is asserted.

The video side is a plain strobe with frame and line markers. It cannot be stalled. The macroblock side is a valid/ready stream: a transfer happens in a cycle where `mb_req` and `mb_rdy` are both high. When `mb_rdy` is low, the position holds. The video side has priority. In a cycle where a video strobe is accepted, `mb_req` is forced low. For that reason `mb_req` may drop without a transfer having taken place. Every accepted access appears on the `mem_*` outputs one clock later.

Top module: `fs_addr_gen`

## Requirements
- R1: After reset, `mem_vld`, `mb_done` and `mem_field` are 0. `mb_req` is 0 with `dir` = 0 and 1 with `dir` = 1.
- R2: The video side starts a frame pass only on a strobe that carries `pix_sof`; strobes before that make no access. The k-th access of a pass (k counting from 0) is to frame offset k. The luma plane takes W·H words, with W = 16·MB_COLS and H = 16·MB_ROWS. Each chroma plane takes (W/2)·(H/2) words. Each access shows on `mem_*` one cycle after its strobe.
- R3: A strobe with `pix_sol` whose column is not 0 jumps to column 0 of the next row before it accesses. That row is offset W in the luma plane.
- R4: Macroblock transfers follow macroblocks in raster order. Within each macroblock they take four 8x8 luma blocks (top-left, top-right, bottom-left, bottom-right), then Cb 8x8, then Cr 8x8. Within each block they go row-major. With 2x1 macroblocks, transfer 384 maps to offset 16 and transfer 767 to offset 767.
- R5: Each cycle with `mb_req` and `mb_rdy` high yields exactly one access. With `mb_rdy` low, no macroblock access happens and the position holds.
- R6: In a cycle where a video strobe is accepted, `mb_req` is 0.
- R7: The writer starts in bank 0 and the reader uses the other bank. The banks swap one cycle after the writer has finished its frame and the reader is done. While the writer waits for that swap, its strobes or transfers are not accepted.
- R8: Frame n (counting from 0) is written at base `FIELD_OFS` when bit 0 of (n+1)/2 is 1, and at base 0 otherwise. It is read back at the same base.
- R9: With `dir` = 1, the video side reads the whole frame twice. `mem_field` is 0 for the first pass and 1 for the second. Each pass waits for a `pix_sof` strobe.
- R10: `mb_done` is a one-cycle pulse that coincides with the output of the last macroblock transfer of a frame.
- R11: `mem_we` is 1 for writer accesses (the video side when `dir` = 0, the macroblock side when `dir` = 1) and 0 for reader accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir | input | 1 | 0: video writes, macroblocks read; 1: the reverse |
| pix_stb | input | 1 | Video sample strobe |
| pix_sof | input | 1 | Strobe is the first sample of a frame or field |
| pix_sol | input | 1 | Strobe is the first sample of a line |
| mb_req | output | 1 | Macroblock side may transfer this cycle (valid) |
| mb_rdy | input | 1 | Macroblock side accepts the transfer (ready) |
| mb_done | output | 1 | Pulse with the last macroblock access of a frame |
| mem_vld | output | 1 | Memory access on the outputs this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_bank | output | 1 | Buffer select |
| mem_addr | output | AW | Word address within the buffer |
| mem_field | output | 1 | Field number of a video-side read |

## Verification
The video side is driven in four ways:
- an unbroken raster sweep, which confirms the plane layout;
- a sweep cut short by a line marker, which separates a true row jump from plain counting;
- strobes without a frame marker, which must cause no access;
- two field passes, where addresses alike and field flags different expose the re-read.

The macroblock side is read with a ready pattern that has gaps, and its addresses are matched at block, chroma-plane and macroblock boundaries. Only the nested ordering gives the right values at those points. Running three frames through both buffers exposes the swap gate and the alternating base offset.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned MB_WORDS = 384;
  localparam int unsigned BLK_SIDE = 8;
  typedef enum logic [1:0] {PL_Y = 2'd0, PL_CB = 2'd1, PL_CR = 2'd2} plane_e;
endpackage

// File: rtl/fs_raster_walk.sv
module fs_raster_walk
  import fs_pkg::*;
#(
  parameter int unsigned W  = 352,
  parameter int unsigned H  = 288,
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb,
  input  logic          sof,
  input  logic          sol,
  output logic          acc,
  output logic          last,
  output logic [AW-1:0] offs
);
  localparam int unsigned CW   = W / 2;
  localparam int unsigned CH   = H / 2;
  localparam int unsigned XW   = $clog2(W);
  localparam int unsigned YW   = $clog2(H);
  localparam int unsigned LUMA = W * H;
  localparam int unsigned CHR  = CW * CH;

  logic          run;
  logic [XW-1:0] x, ux, nx;
  logic [YW-1:0] y, uy, ny;
  plane_e        pl, upl, npl;

  function automatic logic [XW-1:0] xmax(input plane_e p);
    return (p == PL_Y) ? XW'(W - 1) : XW'(CW - 1);
  endfunction

  function automatic logic [YW-1:0] ymax(input plane_e p);
    return (p == PL_Y) ? YW'(H - 1) : YW'(CH - 1);
  endfunction

  function automatic plane_e pnext(input plane_e p);
    case (p)
      PL_Y:    return PL_CB;
      PL_CB:   return PL_CR;
      default: return PL_Y;
    endcase
  endfunction

  function automatic logic [AW-1:0] pbase(input plane_e p);
    case (p)
      PL_Y:    return '0;
      PL_CB:   return AW'(LUMA);
      default: return AW'(LUMA + CHR);
    endcase
  endfunction

  function automatic logic [AW-1:0] pstride(input plane_e p);
    return (p == PL_Y) ? AW'(W) : AW'(CW);
  endfunction

  // position used by this strobe, after marker realignment
  always_comb begin
    ux  = x;
    uy  = y;
    upl = pl;
    if (sof) begin
      ux  = '0;
      uy  = '0;
      upl = PL_Y;
    end else if (sol && x != '0) begin
      ux = '0;
      if (y == ymax(pl)) begin
        uy  = '0;
        upl = pnext(pl);
      end else begin
        uy = y + 1'b1;
      end
    end
    nx  = ux + 1'b1;
    ny  = uy;
    npl = upl;
    if (ux == xmax(upl)) begin
      nx = '0;
      if (uy == ymax(upl)) begin
        ny  = '0;
        npl = pnext(upl);
      end else begin
        ny = uy + 1'b1;
      end
    end
  end

  assign acc  = stb && en && (sof || run);
  assign last = (upl == PL_CR) && (ux == xmax(PL_CR)) && (uy == ymax(PL_CR));
  assign offs = pbase(upl) + AW'(uy) * pstride(upl) + AW'(ux);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      x   <= '0;
      y   <= '0;
      pl  <= PL_Y;
    end else if (acc) begin
      run <= !last;
      x   <= nx;
      y   <= ny;
      pl  <= npl;
    end
  end
endmodule

// File: rtl/fs_mb_walk.sv
module fs_mb_walk
  import fs_pkg::*;
#(
  parameter int unsigned MB_COLS = 22,
  parameter int unsigned MB_ROWS = 18,
  parameter int unsigned AW      = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic          last,
  output logic [AW-1:0] offs
);
  localparam int unsigned W    = MB_COLS * 16;
  localparam int unsigned CW   = W / 2;
  localparam int unsigned LUMA = W * MB_ROWS * 16;
  localparam int unsigned CHR  = LUMA / 4;
  localparam int unsigned CB   = (MB_COLS > 1) ? $clog2(MB_COLS) : 1;
  localparam int unsigned RB   = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1;
  localparam logic [CB-1:0] CMAX = CB'(MB_COLS - 1);
  localparam logic [RB-1:0] RMAX = RB'(MB_ROWS - 1);

  logic [2:0]    j, i, blk;
  logic [CB-1:0] c;
  logic [RB-1:0] r;
  logic [AW-1:0] row, col;

  always_comb begin
    if (blk < 3'd4) begin
      row  = AW'(r) * AW'(16) + (blk[1] ? AW'(BLK_SIDE) : {AW{1'b0}}) + AW'(i);
      col  = AW'(c) * AW'(16) + (blk[0] ? AW'(BLK_SIDE) : {AW{1'b0}}) + AW'(j);
      offs = row * AW'(W) + col;
    end else begin
      row  = AW'(r) * AW'(BLK_SIDE) + AW'(i);
      col  = AW'(c) * AW'(BLK_SIDE) + AW'(j);
      offs = AW'(LUMA) + ((blk == 3'd5) ? AW'(CHR) : {AW{1'b0}}) + row * AW'(CW) + col;
    end
  end

  assign last = (j == 3'd7) && (i == 3'd7) && (blk == 3'd5) && (c == CMAX) && (r == RMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      j   <= '0;
      i   <= '0;
      blk <= '0;
      c   <= '0;
      r   <= '0;
    end else if (step) begin
      j <= j + 1'b1;
      if (j == 3'd7) begin
        i <= i + 1'b1;
        if (i == 3'd7) begin
          if (blk == 3'd5) begin
            blk <= '0;
            if (c == CMAX) begin
              c <= '0;
              r <= (r == RMAX) ? '0 : r + 1'b1;
            end else begin
              c <= c + 1'b1;
            end
          end else begin
            blk <= blk + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fs_bank_ctl.sv
module fs_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic v_end,
  input  logic m_end,
  output logic wb,
  output logic w_ofs,
  output logic r_ofs,
  output logic w_busy,
  output logic r_busy,
  output logic field
);
  logic       w_done, r_done;
  logic [1:0] ofs_bit;
  logic       nb, swap, wr_end, rd_end;

  assign nb     = ~wb;
  assign swap   = w_done && r_done;
  assign wr_end = dir ? m_end : v_end;
  assign rd_end = dir ? v_end : m_end;
  assign w_ofs  = ofs_bit[wb];
  assign r_ofs  = ofs_bit[nb];
  assign w_busy = !w_done;
  assign r_busy = !r_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb      <= 1'b0;
      ofs_bit <= '0;
      w_done  <= 1'b0;
      r_done  <= 1'b1;
      field   <= 1'b0;
    end else if (swap) begin
      wb          <= nb;
      ofs_bit[nb] <= ~ofs_bit[nb];
      w_done      <= 1'b0;
      r_done      <= 1'b0;
      field       <= 1'b0;
    end else begin
      if (wr_end) w_done <= 1'b1;
      if (rd_end) begin
        if (dir && !field) begin
          field <= 1'b1;
        end else begin
          r_done <= 1'b1;
          field  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fs_addr_gen.sv
module fs_addr_gen
  import fs_pkg::*;
#(
  parameter int unsigned MB_COLS   = 22,
  parameter int unsigned MB_ROWS   = 18,
  parameter int unsigned FIELD_OFS = MB_COLS * MB_WORDS,
  localparam int unsigned FRAME_WORDS = MB_COLS * MB_ROWS * MB_WORDS,
  localparam int unsigned AW          = $clog2(FRAME_WORDS + FIELD_OFS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir,
  input  logic          pix_stb,
  input  logic          pix_sof,
  input  logic          pix_sol,
  output logic          mb_req,
  input  logic          mb_rdy,
  output logic          mb_done,
  output logic          mem_vld,
  output logic          mem_we,
  output logic          mem_bank,
  output logic [AW-1:0] mem_addr,
  output logic          mem_field
);
  logic          v_en, v_acc, v_last, m_act, m_acc, m_last;
  logic [AW-1:0] v_offs, m_offs;
  logic          wb, w_ofs, r_ofs, w_busy, r_busy, field;
  logic          acc_wr, acc_ofs;
  logic [AW-1:0] acc_offs;

  assign v_en   = dir ? r_busy : w_busy;
  assign m_act  = dir ? w_busy : r_busy;
  assign mb_req = m_act && !v_acc;
  assign m_acc  = mb_req && mb_rdy;

  fs_raster_walk #(.W(MB_COLS * 16), .H(MB_ROWS * 16), .AW(AW)) u_raster (
    .clk(clk), .rst_n(rst_n), .en(v_en), .stb(pix_stb), .sof(pix_sof), .sol(pix_sol),
    .acc(v_acc), .last(v_last), .offs(v_offs)
  );

  fs_mb_walk #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .AW(AW)) u_mb (
    .clk(clk), .rst_n(rst_n), .step(m_acc), .last(m_last), .offs(m_offs)
  );

  fs_bank_ctl u_bank (
    .clk(clk), .rst_n(rst_n), .dir(dir),
    .v_end(v_acc && v_last), .m_end(m_acc && m_last),
    .wb(wb), .w_ofs(w_ofs), .r_ofs(r_ofs), .w_busy(w_busy), .r_busy(r_busy), .field(field)
  );

  assign acc_wr   = v_acc ? !dir : dir;
  assign acc_ofs  = acc_wr ? w_ofs : r_ofs;
  assign acc_offs = v_acc ? v_offs : m_offs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_vld   <= 1'b0;
      mem_we    <= 1'b0;
      mem_bank  <= 1'b0;
      mem_addr  <= '0;
      mem_field <= 1'b0;
      mb_done   <= 1'b0;
    end else begin
      mem_vld   <= v_acc || m_acc;
      mem_we    <= acc_wr;
      mem_bank  <= acc_wr ? wb : ~wb;
      mem_addr  <= (acc_ofs ? AW'(FIELD_OFS) : {AW{1'b0}}) + acc_offs;
      mem_field <= v_acc && dir && field;
      mb_done   <= m_acc && m_last;
    end
  end
endmodule

// File: rtl/fs_addr_gen_chk.sv
module fs_addr_gen_chk #(
  parameter int unsigned LIMIT = 1,
  parameter int unsigned AW    = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          v_acc,
  input logic          mb_req,
  input logic          mb_rdy,
  input logic          mb_done,
  input logic          mem_vld,
  input logic [AW-1:0] mem_addr,
  input logic          wb,
  input logic          w_busy,
  input logic          r_busy
);
  a_r6_video_wins: assert property (@(posedge clk) disable iff (!rst_n)
    v_acc |-> !mb_req);

  a_r5_xfer_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_req && mb_rdy) |=> mem_vld);

  a_r10_done_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    mb_done |-> mem_vld);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    mb_done |=> !mb_done);

  a_r7_swap_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    (wb != $past(wb)) |-> $past(!w_busy && !r_busy));

  a_r8_addr_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld |-> (32'(mem_addr) < LIMIT));
endmodule

bind fs_addr_gen fs_addr_gen_chk #(.LIMIT(FRAME_WORDS + FIELD_OFS), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .v_acc(v_acc), .mb_req(mb_req), .mb_rdy(mb_rdy),
  .mb_done(mb_done), .mem_vld(mem_vld), .mem_addr(mem_addr), .wb(wb),
  .w_busy(w_busy), .r_busy(r_busy)
);

// File: tb/test_fs_addr_gen.sv
module test_fs_addr_gen;
  localparam int CLK_NS = 10;
  localparam int MBC = 2, MBR = 1, OFS = 40, FW = 768, AW = 10;
  // macroblock transfer index -> expected frame offset (2x1 macroblocks, W=32)
  localparam int MB_VEC [15][2] = '{
    '{0, 0}, '{7, 7}, '{8, 32}, '{63, 231}, '{64, 8}, '{128, 256}, '{255, 495},
    '{256, 512}, '{265, 529}, '{320, 640}, '{383, 759}, '{384, 16}, '{457, 57},
    '{640, 520}, '{767, 767}};

  logic clk = 1'b0, rst_n = 1'b0, dir = 1'b0;
  logic pix_stb = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0, mb_rdy = 1'b0;
  logic mb_req, mb_done, mem_vld, mem_we, mem_bank, mem_field;
  logic [AW-1:0] mem_addr;

  int  total = 0, bad = 0;
  bit  req_seen;
  int  mv_addr [FW];

  fs_addr_gen #(.MB_COLS(MBC), .MB_ROWS(MBR), .FIELD_OFS(OFS)) i_fs_addr_gen (
    .clk(clk), .rst_n(rst_n), .dir(dir), .pix_stb(pix_stb), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .mb_req(mb_req), .mb_rdy(mb_rdy), .mb_done(mb_done),
    .mem_vld(mem_vld), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_field(mem_field)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle; outputs seen afterwards describe this cycle's access
  task automatic step(input bit p, input bit s, input bit l, input bit r);
    pix_stb = p; pix_sof = s; pix_sol = l; mb_rdy = r;
    #1 req_seen = mb_req;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit d);
    rst_n = 1'b0; dir = d;
    pix_stb = 0; pix_sof = 0; pix_sol = 0; mb_rdy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, hs, dn, at_done, errs;
    bit ok;
    @(negedge clk);
    do_reset(1'b0);
    #1;
    check(mem_vld == 0, "R1 vld after reset", int'(mem_vld), 0);
    check(mb_done == 0, "R1 done after reset", int'(mb_done), 0);
    check(mb_req == 0, "R1 req dir0", int'(mb_req), 0);
    check(mem_field == 0, "R1 field after reset", int'(mem_field), 0);

    // R2: strobe without frame marker is ignored
    step(1, 0, 0, 0);
    check(!mem_vld, "R2 no sof no access", int'(mem_vld), 0);
    step(1, 1, 0, 0);
    check(mem_vld && mem_addr == 0 && mem_bank == 0, "R2 first write", int'(mem_addr), 0);
    check(mem_we == 1, "R11 video writes in dir0", int'(mem_we), 1);
    errs = 0;
    for (int k = 1; k < FW; k++) begin
      step(1, 0, 0, 0);
      if (!(mem_vld && mem_we && mem_bank == 0 && int'(mem_addr) == k) || req_seen) errs++;
    end
    check(errs == 0, "R2 raster sweep frame0", errs, 0);
    check(int'(mem_addr) == FW - 1, "R2 last word", int'(mem_addr), FW - 1);

    step(0, 0, 0, 0); // swap edge
    step(1, 1, 0, 1);
    check(req_seen == 0, "R6 video strobe drops mb_req", int'(req_seen), 0);
    check(mem_vld && mem_we && mem_bank == 1 && int'(mem_addr) == OFS,
          "R8 frame1 at offset bank1", int'(mem_addr), OFS);
    step(0, 0, 0, 0);
    check(req_seen == 1, "R7 reader owns frame0", int'(req_seen), 1);
    check(!mem_vld, "R5 no ready no transfer", int'(mem_vld), 0);
    errs = 0;
    for (int k = 1; k < 5; k++) begin
      step(1, 0, 0, 0);
      if (int'(mem_addr) != OFS + k) errs++;
    end
    check(errs == 0, "R2 frame1 start", errs, 0);
    step(1, 0, 1, 0);
    check(mem_vld && int'(mem_addr) == OFS + 32, "R3 line marker jumps row", int'(mem_addr), OFS + 32);
    errs = 0;
    for (int k = 33; k < FW; k++) begin
      step(1, 0, 0, 0);
      if (!(mem_vld && int'(mem_addr) == OFS + k)) errs++;
    end
    check(errs == 0, "R3 rest of frame1", errs, 0);
    step(1, 1, 0, 0);
    check(!mem_vld, "R7 full writer ignores strobe", int'(mem_vld), 0);

    // macroblock read of frame0 with gaps in ready
    n = 0; hs = 0; dn = 0; at_done = -1; ok = 1;
    for (int cyc = 0; cyc < 3000 && n < FW; cyc++) begin
      bit r;
      r = (cyc % 3) != 2;
      step(0, 0, 0, r);
      if (req_seen && r) hs++;
      if (mem_vld) begin
        if (mem_we || mem_bank != 0) ok = 0;
        mv_addr[n] = int'(mem_addr);
        n++;
      end
      if (mb_done) begin dn++; at_done = n; end
    end
    check(n == FW, "R4 transfer count", n, FW);
    check(hs == n, "R5 one access per handshake", n, hs);
    check(ok, "R11 macroblock reads bank0 in dir0", int'(ok), 1);
    check(dn == 1 && at_done == FW, "R10 done on last transfer", at_done, FW);
    foreach (MB_VEC[v]) begin
      check(mv_addr[MB_VEC[v][0]] == MB_VEC[v][1], "R4 macroblock order",
            mv_addr[MB_VEC[v][0]], MB_VEC[v][1]);
    end
    step(0, 0, 0, 0);
    check(!mb_done, "R10 single pulse", int'(mb_done), 0);
    step(0, 0, 0, 1);
    check(req_seen == 1, "R7 second swap", int'(req_seen), 1);
    check(mem_vld && mem_bank == 1 && int'(mem_addr) == OFS, "R8 frame1 read at offset",
          int'(mem_addr), OFS);

    // reverse direction
    do_reset(1'b1);
    #1;
    check(mb_req == 1, "R1 req dir1", int'(mb_req), 1);
    n = 0; ok = 1; dn = 0;
    for (int cyc = 0; cyc < 1000 && n < FW; cyc++) begin
      step(0, 0, 0, 1);
      if (mem_vld) begin
        if (!mem_we || mem_bank != 0) ok = 0;
        mv_addr[n] = int'(mem_addr);
        n++;
      end
      if (mb_done) dn++;
    end
    check(ok && n == FW, "R11 macroblock writes bank0 in dir1", n, FW);
    check(mv_addr[384] == 16 && mv_addr[767] == 767, "R4 write order", mv_addr[384], 16);
    check(dn == 1, "R10 done in dir1", dn, 1);
    step(0, 0, 0, 0); // swap edge
    step(1, 0, 0, 0);
    check(!mem_vld, "R9 read waits for sof", int'(mem_vld), 0);
    for (int f = 0; f < 2; f++) begin
      step(1, 1, 0, 0);
      check(mem_vld && !mem_we && mem_bank == 0 && mem_addr == 0 && int'(mem_field) == f,
            "R9 field start", int'(mem_field), f);
      errs = 0;
      for (int k = 1; k < FW; k++) begin
        step(1, 0, 0, 0);
        if (!(mem_vld && int'(mem_addr) == k && int'(mem_field) == f)) errs++;
      end
      check(errs == 0, "R9 field sweep", errs, 0);
      if (f == 0) begin
        step(1, 0, 0, 0);
        check(!mem_vld, "R9 gap between fields", int'(mem_vld), 0);
      end
    end
    step(1, 1, 0, 0);
    check(!mem_vld, "R7 reader done waits for writer", int'(mem_vld), 0);
    check(req_seen == 1, "R7 macroblock side still writing", int'(req_seen), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule